// File: doc/BRIEF.md
# Decode Stage with Register Scoreboard

This block is the decode step of a small in-order pipeline. Each cycle it may accept one 32-bit instruction word from fetch, tagged by `in_valid`. It identifies the instruction format from the two lowest bits and the operation from the opcode field above them. It then extracts the register and immediate fields and works out which registers the instruction reads and which it will write.

A scoreboard holds one pending bit per architectural register. If any register the instruction reads has a pending bit set, `stall` goes high in the same cycle and nothing changes inside the block, so fetch holds the word and presents it again. Otherwise the block reads the operand values from its internal register file and marks the destinations as pending. One cycle later it presents the decoded operation, operand values, immediate and destination list.

Writeback returns results through a release port. The port writes the value into the register file and clears the register's pending bit. A pending mark set by decode in the same cycle as a release of that register takes priority over the release. The push and pop forms use register 2 as an implicit stack pointer with a fixed step.

Top module: `idec_stage`

## Requirements
- R1: Format comes from bits [1:0] (00 register-register, 01 immediate, 10 jump). Format 11, or an opcode with no operation assigned to it, decodes as NOP (`out_op`=0). A NOP never stalls, reserves nothing, and issues with zero operands and immediate. Register-register opcodes are bits [6:2]: 0..6 are ADD(1) SUB(2) AND(3) OR(4) XOR(5) CMP(6) CEV(7). Immediate opcodes are bits [5:2]: 0..3 are ADDI(8) ORI(9) LOAD(10) STORE(11). Jump opcodes are bits [5:2]: 0..2 are JMP(12) PUSH(13) POP(14). The value in parentheses is the `out_op` code.
- R2: A register-register instruction reads source A from bits [10:7] and source B from bits [14:11]. Its destination is bits [18:15], reported on `out_dst0`. `out_imm` is 0.
- R3: CMP and CEV reserve no destination, and both destination enables are low.
- R4: An immediate-format instruction carries a sign-extended immediate in bits [31:14], with a low field in bits [9:6] and a middle field in bits [13:10]. STORE reads both fields (A=low, B=middle) and reserves nothing. LOAD reads the middle field as A and writes the low field. ADDI and ORI read the low field as A and write the middle field.
- R5: PUSH reads its named register (bits [9:6]) as A and register 2 as B, with `out_imm` = -1. It stalls if either is pending. When it issues, it reserves register 2 on `out_dst1`.
- R6: POP reads register 2 as A with `out_imm` = +1 and stalls only if register 2 is pending. When it issues, it reserves its named register (bits [9:6]) on `out_dst0` and register 2 on `out_dst1`.
- R7: JMP reads only the register in bits [9:6] as A, and `out_imm` is bits [31:10] sign-extended.
- R8: `stall` is high in the same cycle when `in_valid` is high and any register the instruction reads is pending. A stalled word produces no output and changes no pending bit.
- R9: Destinations are reserved only when the instruction issues. Register 0 is never reserved: its destination enable is low.
- R10: A release writes `rel_data` into register `rel_idx` and clears its pending bit at the clock edge. A reservation of the same register in the same cycle wins over the release.
- R11: The decoded result appears registered one cycle after acceptance. `out_valid` is low in the cycle after `in_valid` was low or the word stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 32 | Raw instruction word |
| stall | output | 1 | Word cannot issue this cycle |
| rel_en | input | 1 | Writeback release strobe |
| rel_idx | input | 4 | Register being released |
| rel_data | input | 32 | Result value written on release |
| out_valid | output | 1 | Decoded instruction present |
| out_fmt | output | 2 | Format bits of the issued word |
| out_op | output | 4 | Operation code (see R1) |
| out_a | output | 32 | First operand value |
| out_b | output | 32 | Second operand value |
| out_imm | output | 32 | Immediate, offset or stack step |
| out_dst0 | output | 4 | Primary destination register |
| out_dst0_en | output | 1 | Primary destination reserved |
| out_dst1 | output | 4 | Stack-pointer destination register |
| out_dst1_en | output | 1 | Stack-pointer destination reserved |

## Verification
The assertions take every input as known from the first clock after reset. The release assertion expects at most one release per cycle, which the single-port interface already ensures. No property assumes that a released register was actually pending, so the preload phase, which releases registers with nothing outstanding to seed the file with values, stays legal. In the random phase the stimulus releases only registers that its model holds as pending, as real writeback would. Directed sequences then reach the corner cases on purpose: reservation and release of the same register in one cycle, register 0 as destination, and stack operations colliding on register 2.

// File: rtl/idec_pkg.sv
// Shared encodings for the decode stage: instruction formats and the
// operation codes reported on out_op.
package idec_pkg;

    localparam int FMT_W = 2;

    typedef enum logic [1:0] {
        FMT_RR  = 2'b00,
        FMT_IMM = 2'b01,
        FMT_JMP = 2'b10,
        FMT_BAD = 2'b11
    } fmt_e;

    typedef enum logic [3:0] {
        M_NOP   = 4'd0,
        M_ADD   = 4'd1,
        M_SUB   = 4'd2,
        M_AND   = 4'd3,
        M_OR    = 4'd4,
        M_XOR   = 4'd5,
        M_CMP   = 4'd6,
        M_CEV   = 4'd7,
        M_ADDI  = 4'd8,
        M_ORI   = 4'd9,
        M_LOAD  = 4'd10,
        M_STORE = 4'd11,
        M_JMP   = 4'd12,
        M_PUSH  = 4'd13,
        M_POP   = 4'd14
    } mnem_e;

endpackage

// File: rtl/idec_split.sv
// Field splitter: finds the format and operation of a raw word and cuts
// out the register and immediate fields. Pure combinational logic.
// Assumes the register-register opcode is wider than the opcode of the
// other formats. Field offsets follow from the widths given as parameters.
module idec_split
    import idec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int RW    = 4,
    parameter int ROP_W = 5,
    parameter int OP_W  = 4
) (
    input  logic [XLEN-1:0] word,
    output fmt_e            fmt,
    output mnem_e           mnem,
    output logic [RW-1:0]   fld_lo,
    output logic [RW-1:0]   fld_mid,
    output logic [RW-1:0]   fld_hi,
    output logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] imm_j
);
    localparam int RSH    = FMT_W + ROP_W;
    localparam int ISH    = FMT_W + OP_W;
    localparam int IIMM_W = XLEN - ISH - 2 * RW;
    localparam int JIMM_W = XLEN - ISH - RW;

    logic [ROP_W-1:0] rop;
    logic [OP_W-1:0]  op;

    assign fmt = fmt_e'(word[FMT_W-1:0]);
    assign rop = word[FMT_W +: ROP_W];
    assign op  = word[FMT_W +: OP_W];

    // Immediates always end at the top bit of the word, so the sign is bit XLEN-1.
    assign imm_i = {{(XLEN - IIMM_W){word[XLEN-1]}}, word[XLEN-1 -: IIMM_W]};
    assign imm_j = {{(XLEN - JIMM_W){word[XLEN-1]}}, word[XLEN-1 -: JIMM_W]};

    // Register fields start just above the opcode, whose width depends on format.
    always_comb begin
        if (fmt == FMT_RR) begin
            fld_lo  = word[RSH +: RW];
            fld_mid = word[RSH + RW +: RW];
            fld_hi  = word[RSH + 2 * RW +: RW];
        end else begin
            fld_lo  = word[ISH +: RW];
            fld_mid = word[ISH + RW +: RW];
            fld_hi  = '0;
        end
    end

    // Operation lookup; any unlisted format/opcode pair falls back to NOP.
    always_comb begin
        mnem = M_NOP;
        unique case (fmt)
            FMT_RR: begin
                if      (rop == ROP_W'(0)) mnem = M_ADD;
                else if (rop == ROP_W'(1)) mnem = M_SUB;
                else if (rop == ROP_W'(2)) mnem = M_AND;
                else if (rop == ROP_W'(3)) mnem = M_OR;
                else if (rop == ROP_W'(4)) mnem = M_XOR;
                else if (rop == ROP_W'(5)) mnem = M_CMP;
                else if (rop == ROP_W'(6)) mnem = M_CEV;
            end
            FMT_IMM: begin
                if      (op == OP_W'(0)) mnem = M_ADDI;
                else if (op == OP_W'(1)) mnem = M_ORI;
                else if (op == OP_W'(2)) mnem = M_LOAD;
                else if (op == OP_W'(3)) mnem = M_STORE;
            end
            FMT_JMP: begin
                if      (op == OP_W'(0)) mnem = M_JMP;
                else if (op == OP_W'(1)) mnem = M_PUSH;
                else if (op == OP_W'(2)) mnem = M_POP;
            end
            default: mnem = M_NOP;
        endcase
    end

endmodule

// File: rtl/idec_plan.sv
// Operand planner: from the operation and the raw fields, decides which
// registers are read (up to two), which are reserved (up to two), and the
// immediate. Register 0 is never offered as a reserved destination.
module idec_plan
    import idec_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RW     = 4,
    parameter int SP_IDX = 2
) (
    input  mnem_e           mnem,
    input  logic [RW-1:0]   fld_lo,
    input  logic [RW-1:0]   fld_mid,
    input  logic [RW-1:0]   fld_hi,
    input  logic [XLEN-1:0] imm_i,
    input  logic [XLEN-1:0] imm_j,
    output logic [RW-1:0]   src0,
    output logic            src0_use,
    output logic [RW-1:0]   src1,
    output logic            src1_use,
    output logic [RW-1:0]   dst0,
    output logic            dst0_en,
    output logic [RW-1:0]   dst1,
    output logic            dst1_en,
    output logic [XLEN-1:0] imm
);
    localparam logic [RW-1:0] SP = RW'(SP_IDX);

    logic [RW-1:0] d0_raw;
    logic          d0_want;
    logic          d1_want;

    // Role assignment per operation.
    always_comb begin
        src0 = '0; src0_use = 1'b0;
        src1 = '0; src1_use = 1'b0;
        d0_raw = '0; d0_want = 1'b0;
        d1_want = 1'b0;
        imm = '0;
        unique case (mnem)
            M_ADD, M_SUB, M_AND, M_OR, M_XOR: begin
                src0 = fld_lo;  src0_use = 1'b1;
                src1 = fld_mid; src1_use = 1'b1;
                d0_raw = fld_hi; d0_want = 1'b1;
            end
            M_CMP, M_CEV: begin
                src0 = fld_lo;  src0_use = 1'b1;
                src1 = fld_mid; src1_use = 1'b1;
            end
            M_ADDI, M_ORI: begin
                src0 = fld_lo; src0_use = 1'b1;
                d0_raw = fld_mid; d0_want = 1'b1;
                imm = imm_i;
            end
            M_LOAD: begin
                src0 = fld_mid; src0_use = 1'b1;
                d0_raw = fld_lo; d0_want = 1'b1;
                imm = imm_i;
            end
            M_STORE: begin
                src0 = fld_lo;  src0_use = 1'b1;
                src1 = fld_mid; src1_use = 1'b1;
                imm = imm_i;
            end
            M_JMP: begin
                src0 = fld_lo; src0_use = 1'b1;
                imm = imm_j;
            end
            M_PUSH: begin
                src0 = fld_lo; src0_use = 1'b1;
                src1 = SP;     src1_use = 1'b1;
                d1_want = 1'b1;
                imm = '1;
            end
            M_POP: begin
                src0 = SP; src0_use = 1'b1;
                d0_raw = fld_lo; d0_want = 1'b1;
                d1_want = 1'b1;
                imm = XLEN'(1);
            end
            default: ;
        endcase
    end

    // Drop any reservation of register 0 and zero unused indices.
    always_comb begin
        dst0_en = d0_want && (d0_raw != '0);
        dst0    = dst0_en ? d0_raw : '0;
        dst1_en = d1_want && (SP != '0);
        dst1    = dst1_en ? SP : '0;
    end

endmodule

// File: rtl/idec_scoreboard.sv
// Pending-write scoreboard: one bit per register. Decode sets bits with a
// mask; writeback clears one bit per cycle. A set beats a clear on the
// same bit. Assumes the set mask never contains register 0.
module idec_scoreboard #(
    parameter  int NREG = 16,
    localparam int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] set_mask,
    input  logic            clr_en,
    input  logic [RW-1:0]   clr_idx,
    output logic [NREG-1:0] busy
);
    logic [NREG-1:0] clr_hot;
    logic [NREG-1:0] busy_nx;

    // Per-register release decode.
    for (genvar i = 0; i < NREG; i++) begin : g_clr
        assign clr_hot[i] = clr_en && (clr_idx == RW'(i));
    end

    // Next state: clear first, then set so that a set takes priority.
    always_comb busy_nx = (busy & ~clr_hot) | set_mask;

    // Pending-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= busy_nx;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((busy & $past(set_mask)) == $past(set_mask)));

    // R10
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_mask[clr_idx]) |=> !busy[$past(clr_idx)]);

    // R9
    zero_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy[0]);

endmodule

// File: rtl/idec_regfile.sv
// Register file with two combinational read ports and one write port fed
// by writeback. Register 0 ignores writes and always reads zero.
module idec_regfile #(
    parameter  int XLEN = 32,
    parameter  int NREG = 16,
    localparam int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RW-1:0]   widx,
    input  logic [XLEN-1:0] wdata,
    input  logic [RW-1:0]   ridx0,
    input  logic [RW-1:0]   ridx1,
    output logic [XLEN-1:0] rdata0,
    output logic [XLEN-1:0] rdata1
);
    logic [XLEN-1:0] regs [NREG];

    // Storage update from writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (widx != '0)) begin
            regs[widx] <= wdata;
        end
    end

    assign rdata0 = regs[ridx0];
    assign rdata1 = regs[ridx1];

endmodule

// File: rtl/idec_stage.sv
// Decode stage top. Splits the word, plans its operands, checks the reads
// against the scoreboard, and on issue registers the decoded result and
// reserves destinations. A stall is combinational and leaves all state alone.
// Assumes fetch holds a stalled word until it issues.
module idec_stage
    import idec_pkg::*;
#(
    parameter  int XLEN   = 32,
    parameter  int NREG   = 16,
    parameter  int ROP_W  = 5,
    parameter  int OP_W   = 4,
    parameter  int SP_IDX = 2,
    localparam int RW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_word,
    output logic            stall,
    input  logic            rel_en,
    input  logic [RW-1:0]   rel_idx,
    input  logic [XLEN-1:0] rel_data,
    output logic            out_valid,
    output logic [1:0]      out_fmt,
    output logic [3:0]      out_op,
    output logic [XLEN-1:0] out_a,
    output logic [XLEN-1:0] out_b,
    output logic [XLEN-1:0] out_imm,
    output logic [RW-1:0]   out_dst0,
    output logic            out_dst0_en,
    output logic [RW-1:0]   out_dst1,
    output logic            out_dst1_en
);
    fmt_e            fmt;
    mnem_e           mnem;
    logic [RW-1:0]   f_lo, f_mid, f_hi;
    logic [XLEN-1:0] imm_i, imm_j, imm;
    logic [RW-1:0]   src0, src1, dst0, dst1;
    logic            src0_use, src1_use, dst0_en, dst1_en;
    logic [XLEN-1:0] rd0, rd1;
    logic [NREG-1:0] busy;
    logic [NREG-1:0] set_mask;
    logic            hazard;
    logic            issue;

    idec_split #(.XLEN(XLEN), .RW(RW), .ROP_W(ROP_W), .OP_W(OP_W)) u_split (
        .word(in_word), .fmt(fmt), .mnem(mnem),
        .fld_lo(f_lo), .fld_mid(f_mid), .fld_hi(f_hi),
        .imm_i(imm_i), .imm_j(imm_j)
    );

    idec_plan #(.XLEN(XLEN), .RW(RW), .SP_IDX(SP_IDX)) u_plan (
        .mnem(mnem), .fld_lo(f_lo), .fld_mid(f_mid), .fld_hi(f_hi),
        .imm_i(imm_i), .imm_j(imm_j),
        .src0(src0), .src0_use(src0_use), .src1(src1), .src1_use(src1_use),
        .dst0(dst0), .dst0_en(dst0_en), .dst1(dst1), .dst1_en(dst1_en),
        .imm(imm)
    );

    idec_scoreboard #(.NREG(NREG)) u_sb (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask),
        .clr_en(rel_en), .clr_idx(rel_idx), .busy(busy)
    );

    idec_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rel_en), .widx(rel_idx), .wdata(rel_data),
        .ridx0(src0), .ridx1(src1), .rdata0(rd0), .rdata1(rd1)
    );

    // Hazard check: any read of a pending register blocks issue.
    always_comb begin
        hazard = (src0_use && busy[src0]) || (src1_use && busy[src1]);
        stall  = in_valid && (mnem != M_NOP) && hazard;
        issue  = in_valid && !stall;
    end

    // Reservation mask, only for an issuing instruction.
    always_comb begin
        set_mask = '0;
        if (issue && dst0_en) set_mask[dst0] = 1'b1;
        if (issue && dst1_en) set_mask[dst1] = 1'b1;
    end

    // Output register toward execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_fmt     <= '0;
            out_op      <= '0;
            out_a       <= '0;
            out_b       <= '0;
            out_imm     <= '0;
            out_dst0    <= '0;
            out_dst0_en <= 1'b0;
            out_dst1    <= '0;
            out_dst1_en <= 1'b0;
        end else begin
            out_valid <= issue;
            if (issue) begin
                out_fmt     <= fmt;
                out_op      <= mnem;
                out_a       <= src0_use ? rd0 : '0;
                out_b       <= src1_use ? rd1 : '0;
                out_imm     <= imm;
                out_dst0    <= dst0;
                out_dst0_en <= dst0_en;
                out_dst1    <= dst1;
                out_dst1_en <= dst1_en;
            end
        end
    end

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !out_valid);

    // R8
    stall_keeps_sb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !rel_en) |=> $stable(busy));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    cmp_nodst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((out_op == 4'(M_CMP)) || (out_op == 4'(M_CEV))))
            |-> (!out_dst0_en && !out_dst1_en));

    // R9
    issue_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst0_en) |-> busy[out_dst0]);

endmodule

// File: tb/idec_stage_test.sv
`timescale 1ns/1ps
module idec_stage_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        stall;
    logic        rel_en = 1'b0;
    logic [3:0]  rel_idx = '0;
    logic [31:0] rel_data = '0;
    logic        out_valid;
    logic [1:0]  out_fmt;
    logic [3:0]  out_op;
    logic [31:0] out_a, out_b, out_imm;
    logic [3:0]  out_dst0, out_dst1;
    logic        out_dst0_en, out_dst1_en;

    idec_stage uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .stall(stall), .rel_en(rel_en), .rel_idx(rel_idx), .rel_data(rel_data),
        .out_valid(out_valid), .out_fmt(out_fmt), .out_op(out_op),
        .out_a(out_a), .out_b(out_b), .out_imm(out_imm),
        .out_dst0(out_dst0), .out_dst0_en(out_dst0_en),
        .out_dst1(out_dst1), .out_dst1_en(out_dst1_en)
    );

    always #10 clk = ~clk;  // 50 MHz

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;

    // Behavioural model state.
    logic [31:0] m_rf [16];
    bit          m_busy [16];

    // Expected results for the word currently driven.
    logic [3:0]  e_op;
    logic [1:0]  e_fmt;
    logic [31:0] e_a, e_b, e_imm;
    logic [3:0]  e_d0, e_d1;
    bit          e_d0en, e_d1en, e_stall;
    string       e_tag;
    bit          last_stall;

    task automatic chk_eq(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_r(int op, int s1, int s2, int d);
        return {13'd0, 4'(d), 4'(s2), 4'(s1), 5'(op), 2'b00};
    endfunction
    function automatic logic [31:0] mk_i(int op, int lo, int mid, int imm);
        return {18'(imm), 4'(mid), 4'(lo), 4'(op), 2'b01};
    endfunction
    function automatic logic [31:0] mk_j(int op, int lo, int off);
        return {22'(off), 4'(lo), 4'(op), 2'b10};
    endfunction

    // Decode per the requirements, using the model's register and busy state.
    task automatic model_decode(input logic v, input logic [31:0] w);
        int lo, mid, hi, s0, s1;
        bit u0, u1;
        logic [31:0] iimm, jimm;
        e_fmt = w[1:0];
        e_op = 0; e_a = 0; e_b = 0; e_imm = 0;
        e_d0 = 0; e_d1 = 0; e_d0en = 0; e_d1en = 0;
        u0 = 0; u1 = 0; s0 = 0; s1 = 0; e_tag = "R1";
        iimm = {{14{w[31]}}, w[31:14]};
        jimm = {{10{w[31]}}, w[31:10]};
        if (w[1:0] == 2'b00) begin
            lo = int'(w[10:7]); mid = int'(w[14:11]); hi = int'(w[18:15]);
            if (w[6:2] <= 5'd6) begin
                e_op = 4'(int'(w[6:2]) + 1);
                e_tag = (e_op >= 6) ? "R3" : "R2";
                u0 = 1; s0 = lo; u1 = 1; s1 = mid;
                if (e_op < 6 && hi != 0) begin e_d0en = 1; e_d0 = 4'(hi); end
            end
        end else if (w[1:0] == 2'b01) begin
            lo = int'(w[9:6]); mid = int'(w[13:10]);
            if (w[5:2] <= 4'd3) begin
                e_op = 4'(int'(w[5:2]) + 8);
                e_tag = "R4"; e_imm = iimm;
                if (e_op == 10) begin
                    u0 = 1; s0 = mid;
                    if (lo != 0) begin e_d0en = 1; e_d0 = 4'(lo); end
                end else if (e_op == 11) begin
                    u0 = 1; s0 = lo; u1 = 1; s1 = mid;
                end else begin
                    u0 = 1; s0 = lo;
                    if (mid != 0) begin e_d0en = 1; e_d0 = 4'(mid); end
                end
            end
        end else if (w[1:0] == 2'b10) begin
            lo = int'(w[9:6]);
            if (w[5:2] == 4'd0) begin
                e_op = 12; e_tag = "R7"; u0 = 1; s0 = lo; e_imm = jimm;
            end else if (w[5:2] == 4'd1) begin
                e_op = 13; e_tag = "R5"; u0 = 1; s0 = lo; u1 = 1; s1 = 2;
                e_imm = 32'hFFFF_FFFF; e_d1en = 1; e_d1 = 2;
            end else if (w[5:2] == 4'd2) begin
                e_op = 14; e_tag = "R6"; u0 = 1; s0 = 2; e_imm = 1;
                e_d1en = 1; e_d1 = 2;
                if (lo != 0) begin e_d0en = 1; e_d0 = 4'(lo); end
            end
        end
        if (u0) e_a = m_rf[s0];
        if (u1) e_b = m_rf[s1];
        e_stall = v && ((u0 && m_busy[s0]) || (u1 && m_busy[s1]));
    endtask

    // One clock of stimulus, checks and model update.
    task automatic step(input logic v, input logic [31:0] w,
                        input logic rv, input int ri, input logic [31:0] rd);
        bit iss;
        in_valid = v; in_word = w;
        rel_en = rv; rel_idx = 4'(ri); rel_data = rd;
        model_decode(v, w);
        #1;
        chk_eq("R8", "stall", 32'(stall), 32'(e_stall));
        last_stall = stall;
        @(posedge clk); #1;
        iss = v && !e_stall;
        chk_eq("R11", "out_valid", 32'(out_valid), 32'(iss));
        if (iss) begin
            chk_eq(e_tag, "out_fmt", 32'(out_fmt), 32'(e_fmt));
            chk_eq(e_tag, "out_op", 32'(out_op), 32'(e_op));
            chk_eq(e_tag, "out_a", out_a, e_a);
            chk_eq(e_tag, "out_b", out_b, e_b);
            chk_eq(e_tag, "out_imm", out_imm, e_imm);
            chk_eq("R9", "dst0_en", 32'(out_dst0_en), 32'(e_d0en));
            chk_eq("R9", "dst1_en", 32'(out_dst1_en), 32'(e_d1en));
            if (e_d0en) chk_eq(e_tag, "dst0", 32'(out_dst0), 32'(e_d0));
            if (e_d1en) chk_eq(e_tag, "dst1", 32'(out_dst1), 32'(e_d1));
        end
        // Model update: release clears, reservation wins.
        if (rv) begin
            if (ri != 0) m_rf[ri] = rd;
            m_busy[ri] = 0;
        end
        if (iss && e_d0en) m_busy[e_d0] = 1;
        if (iss && e_d1en) m_busy[e_d1] = 1;
        @(negedge clk);
    endtask

    task automatic idle(input logic rv, input int ri, input logic [31:0] rd);
        step(1'b0, 32'd0, rv, ri, rd);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_rf[i] = 0; m_busy[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state
        chk_eq("R11", "reset out_valid", 32'(out_valid), 0);
        chk_eq("R8", "reset stall", 32'(stall), 0);
        rst_n = 1'b1;

        // Preload register values through the release port (R10).
        for (int i = 1; i < 16; i++) idle(1'b1, i, 32'(i * 32'h0101_0011));

        // R2 issue, then a dependent read stalls (R8).
        step(1, mk_r(0, 1, 2, 3), 0, 0, 0);
        step(1, mk_r(1, 3, 4, 5), 0, 0, 0);
        chk_eq("R8", "dependent read stalls", 32'(last_stall), 1);
        step(1, mk_r(1, 3, 4, 5), 0, 0, 0);
        chk_eq("R8", "stall holds", 32'(last_stall), 1);
        // R10 release delivers data
        idle(1, 3, 32'h0000_1234);
        step(1, mk_r(0, 3, 3, 6), 0, 0, 0);
        chk_eq("R10", "released value read", out_a, 32'h1234);
        idle(1, 6, 32'hABCD);

        // R3 compare reserves nothing
        step(1, mk_r(5, 1, 2, 7), 0, 0, 0);
        step(1, mk_r(6, 1, 2, 7), 0, 0, 0);
        step(1, mk_r(0, 7, 1, 8), 0, 0, 0);
        chk_eq("R3", "compare dest not pending", 32'(last_stall), 0);

        // R9 register 0 never reserved
        step(1, mk_r(2, 1, 2, 0), 0, 0, 0);
        step(1, mk_r(0, 0, 0, 9), 0, 0, 0);
        chk_eq("R9", "r0 not pending", 32'(last_stall), 0);

        // R10 set wins over release of r9 in same cycle
        step(1, mk_r(3, 1, 2, 9), 1, 9, 32'h55);
        step(1, mk_r(0, 9, 1, 10), 0, 0, 0);
        chk_eq("R10", "set beats release", 32'(last_stall), 1);
        idle(1, 9, 32'h99);
        idle(1, 8, 32'h88);

        // R4 load / store / addi
        step(1, mk_i(2, 10, 1, -5), 0, 0, 0);
        step(1, mk_i(3, 10, 1, 7), 0, 0, 0);
        chk_eq("R4", "store waits on loaded reg", 32'(last_stall), 1);
        idle(1, 10, 32'hA0);
        step(1, mk_i(3, 10, 1, 7), 0, 0, 0);
        step(1, mk_i(0, 4, 11, 131071), 0, 0, 0);
        step(1, mk_i(1, 11, 12, -131072), 0, 0, 0);
        chk_eq("R4", "addi dest blocks ori", 32'(last_stall), 1);
        idle(1, 11, 32'hB0);

        // R5 push, R6 pop colliding on r2
        step(1, mk_j(1, 4, 0), 0, 0, 0);
        step(1, mk_j(2, 5, 0), 0, 0, 0);
        chk_eq("R6", "pop waits on sp", 32'(last_stall), 1);
        idle(1, 2, 32'h8000);
        step(1, mk_j(2, 5, 0), 0, 0, 0);
        step(1, mk_r(0, 5, 1, 13), 0, 0, 0);
        chk_eq("R6", "pop dest pending", 32'(last_stall), 1);
        step(1, mk_j(1, 1, 0), 0, 0, 0);
        chk_eq("R5", "push waits on sp", 32'(last_stall), 1);
        idle(1, 5, 32'h5);
        idle(1, 2, 32'h7FFF);

        // R7 jump with negative offset
        step(1, mk_j(0, 1, -100), 0, 0, 0);
        step(1, mk_j(0, 1, 2097151), 0, 0, 0);

        // R1 invalid format and undefined opcode with pending regs: no stall
        step(1, mk_r(0, 1, 2, 14), 0, 0, 0);
        step(1, 32'hFFFF_FFFF, 0, 0, 0);
        chk_eq("R1", "invalid format no stall", 32'(last_stall), 0);
        step(1, mk_r(20, 14, 14, 14), 0, 0, 0);
        chk_eq("R1", "undefined op no stall", 32'(last_stall), 0);
        step(1, mk_j(9, 14, 3), 0, 0, 0);
        step(1, mk_i(7, 14, 14, 3), 0, 0, 0);
        idle(1, 14, 32'hE);

        // Random phase with releases of pending registers only.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            bit rv;
            int ri;
            w = $urandom;
            rv = 0; ri = 0;
            if ($urandom_range(0, 1) == 1) begin
                int st;
                st = $urandom_range(0, 15);
                for (int k = 0; k < 16; k++) begin
                    if (!rv && m_busy[(st + k) % 16]) begin
                        rv = 1; ri = (st + k) % 16;
                    end
                end
            end
            step($urandom_range(0, 7) != 0, w, rv, ri, $urandom);
        end

        idle(0, 0, 0);
        finish_run();
    end

endmodule